// File: doc/BRIEF.md
# Dual-Channel Broadcast Link Sender

This block takes a stream of 32-bit words, each with a one-bit control flag, from a front-end source running on its own clock. It carries them across an asynchronous FIFO into the link clock domain. The link clock is the one that also clocks the serializer interfaces. Every word that leaves the FIFO goes out in the same cycle on two parallel word channels. Each channel feeds its own serializer.

Each channel has its own pause request from its far-end receiver. Either request alone stops the FIFO from being read. The two channels therefore never drift apart by even one word. Backpressure reaches the source through the FIFO: once it fills, the source sees its ready signal drop.

Per channel, the block reports the synchronized pause level and a sticky flag. The sticky flag records that the channel has paused at least once since reset. On cycles with no word to send, each channel shows an idle pattern of all zeros instead of stale data.

Top module: `dual_link_sender`

## Requirements
- R1: While reset is held and right after it, `ch_valid`, `ch_data`, `ch_ctrl` and `ch_pause_seen` are all zero and `src_ready` is 1.
- R2: Every word accepted at the source appears exactly once on each channel, with its control flag, in acceptance order. Channel i occupies bits [32*i+31:32*i] of `ch_data` and bit i of `ch_ctrl`.
- R3: On every link clock cycle the bits of `ch_valid` are either all 0 or all 1.
- R4: Once a channel's pause request has been high for three link clock edges, no channel presents a valid word for as long as it stays high.
- R5: While any pause is held and the source keeps offering words, `src_ready` goes low after the FIFO has absorbed its capacity.
- R6: On every cycle where a channel's valid bit is 0, that channel's data and control bits are 0.
- R7: A channel's `ch_pause_seen` bit is set after its synchronized pause is seen. It then stays set until reset, including after the pause is released.
- R8: A word offered with `src_valid` high while `src_ready` is low is not accepted and never appears on any channel.
- R9: When all pauses are released, the words held in the FIFO are delivered on both channels with none lost and none repeated.
- R10: `ch_paused` bit i shows channel i's pause request after two link clock edges of synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Front-end source clock |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| src_valid | input | 1 | Source offers a word this cycle |
| src_data | input | 32 | Word from the source |
| src_ctrl | input | 1 | Control flag carried with the word |
| src_ready | output | 1 | FIFO can take a word (not full) |
| lnk_clk | input | 1 | Link / serializer-interface clock |
| lnk_rst | input | 1 | Synchronous active-high reset, link domain |
| ch_pause_req | input | NUM_CH | Per-channel pause request from receiver, asynchronous |
| ch_valid | output | NUM_CH | Per-channel word-valid strobe |
| ch_data | output | 32*NUM_CH | Per-channel word, channel i in slice i |
| ch_ctrl | output | NUM_CH | Per-channel control flag |
| ch_paused | output | NUM_CH | Synchronized pause level per channel |
| ch_pause_seen | output | NUM_CH | Sticky flag: channel has paused since reset |

## Verification
The bench builds the block with an eight-entry FIFO (ADDR_W of 3) and two channels. A few dozen words are enough to fill the FIFO, drop `src_ready`, and wrap both Gray pointers many times over. It runs through every nonzero pause pattern: channel 0 alone, channel 1 alone, and both. For each, it checks the halt, the full FIFO and the lossless drain. Runs with the source and link clocks out of ratio exercise the pointer synchronizers in both directions. A final run with a rapidly toggling pause on one channel checks that lockstep delivery holds while backpressure changes from cycle to cycle.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int WORD_W = 32;

    // One beat on a channel: control flag plus payload word.
    typedef struct packed {
        logic              tag;
        logic [WORD_W-1:0] word;
    } lane_beat_t;

    localparam int BEAT_W = $bits(lane_beat_t);

    // Beat shown on a channel when nothing is sent.
    function automatic lane_beat_t idle_beat();
        lane_beat_t b;
        b = '0;
        return b;
    endfunction

endpackage

// File: rtl/dol_sync2.sv
module dol_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dol_afifo.sv
module dol_afifo
    import lnk_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic       wclk,
    input  logic       wrst,
    input  logic       wen,
    input  lane_beat_t wbeat,
    output logic       full,
    input  logic       rclk,
    input  logic       rrst,
    input  logic       ren,
    output lane_beat_t rbeat,
    output logic       empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    lane_beat_t mem [DEPTH];

    logic [PW-1:0] wbin, wgray, wbin_nxt;
    logic [PW-1:0] rbin, rgray, rbin_nxt;
    logic [PW-1:0] wgray_at_r, rgray_at_w;

    // Write side
    assign wbin_nxt = wbin + PW'(wen && !full);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wen && !full)
            mem[wbin[ADDR_W-1:0]] <= wbeat;
    end

    dol_sync2 #(.W(PW)) u_rptr_sync (
        .clk (wclk),
        .rst (wrst),
        .d   (rgray),
        .q   (rgray_at_w)
    );

    assign full = (wgray == {~rgray_at_w[PW-1:PW-2], rgray_at_w[PW-3:0]});

    // Read side
    assign rbin_nxt = rbin + PW'(ren && !empty);

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    dol_sync2 #(.W(PW)) u_wptr_sync (
        .clk (rclk),
        .rst (rrst),
        .d   (wgray),
        .q   (wgray_at_r)
    );

    assign empty = (rgray == wgray_at_r);
    assign rbeat = mem[rbin[ADDR_W-1:0]];
endmodule

// File: rtl/dol_fanout.sv
module dol_fanout
    import lnk_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH-1:0]       hold,
    input  logic                    fifo_empty,
    input  lane_beat_t              fifo_beat,
    output logic                    pop,
    output logic [NUM_CH-1:0]       lane_valid,
    output lane_beat_t [NUM_CH-1:0] lane_beat,
    output logic [NUM_CH-1:0]       lane_seen
);
    // A single pop decision feeds every lane, so lanes cannot diverge.
    assign pop = !fifo_empty && !(|hold);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_valid[i] <= 1'b0;
                lane_beat[i]  <= idle_beat();
                lane_seen[i]  <= 1'b0;
            end else begin
                lane_valid[i] <= pop;
                lane_beat[i]  <= pop ? fifo_beat : idle_beat();
                lane_seen[i]  <= lane_seen[i] | hold[i];
            end
        end
    end
endmodule

// File: rtl/dual_link_sender.sv
module dual_link_sender
    import lnk_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int NUM_CH = 2
) (
    input  logic                     src_clk,
    input  logic                     src_rst,
    input  logic                     src_valid,
    input  logic [WORD_W-1:0]        src_data,
    input  logic                     src_ctrl,
    output logic                     src_ready,
    input  logic                     lnk_clk,
    input  logic                     lnk_rst,
    input  logic [NUM_CH-1:0]        ch_pause_req,
    output logic [NUM_CH-1:0]        ch_valid,
    output logic [NUM_CH*WORD_W-1:0] ch_data,
    output logic [NUM_CH-1:0]        ch_ctrl,
    output logic [NUM_CH-1:0]        ch_paused,
    output logic [NUM_CH-1:0]        ch_pause_seen
);
    lane_beat_t               in_beat, head_beat;
    logic                     fifo_full, fifo_empty, fifo_pop;
    lane_beat_t [NUM_CH-1:0]  lane_beat;

    assign in_beat   = '{tag: src_ctrl, word: src_data};
    assign src_ready = !fifo_full;

    dol_afifo #(.ADDR_W(ADDR_W)) u_fifo (
        .wclk  (src_clk),
        .wrst  (src_rst),
        .wen   (src_valid),
        .wbeat (in_beat),
        .full  (fifo_full),
        .rclk  (lnk_clk),
        .rrst  (lnk_rst),
        .ren   (fifo_pop),
        .rbeat (head_beat),
        .empty (fifo_empty)
    );

    dol_sync2 #(.W(NUM_CH)) u_pause_sync (
        .clk (lnk_clk),
        .rst (lnk_rst),
        .d   (ch_pause_req),
        .q   (ch_paused)
    );

    dol_fanout #(.NUM_CH(NUM_CH)) u_fanout (
        .clk        (lnk_clk),
        .rst        (lnk_rst),
        .hold       (ch_paused),
        .fifo_empty (fifo_empty),
        .fifo_beat  (head_beat),
        .pop        (fifo_pop),
        .lane_valid (ch_valid),
        .lane_beat  (lane_beat),
        .lane_seen  (ch_pause_seen)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flat
        assign ch_data[i*WORD_W +: WORD_W] = lane_beat[i].word;
        assign ch_ctrl[i]                  = lane_beat[i].tag;
    end
endmodule

// File: rtl/dual_link_sender_chk.sv
module dual_link_sender_chk #(
    parameter int NUM_CH = 2,
    parameter int WORD_W = 32
) (
    input logic                     lnk_clk,
    input logic                     lnk_rst,
    input logic [NUM_CH-1:0]        ch_valid,
    input logic [NUM_CH*WORD_W-1:0] ch_data,
    input logic [NUM_CH-1:0]        ch_ctrl,
    input logic [NUM_CH-1:0]        ch_paused,
    input logic [NUM_CH-1:0]        ch_pause_seen
);
    AST_LOCKSTEP_VALID: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
        (ch_valid == '0) || (ch_valid == '1)); // R3

    AST_HALT_ON_PAUSE: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
        (|ch_paused) |=> (ch_valid == '0)); // R4

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        AST_IDLE_ZERO: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
            !ch_valid[i] |-> (ch_data[i*WORD_W +: WORD_W] == '0 && !ch_ctrl[i])); // R6

        AST_SAME_WORD: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
            ch_valid[i] |-> (ch_data[i*WORD_W +: WORD_W] == ch_data[WORD_W-1:0]
                             && ch_ctrl[i] == ch_ctrl[0])); // R2

        AST_SEEN_STICKY: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
            ch_pause_seen[i] |=> ch_pause_seen[i]); // R7

        AST_SEEN_SETS: assert property (@(posedge lnk_clk) disable iff (lnk_rst)
            ch_paused[i] |=> ch_pause_seen[i]); // R7
    end
endmodule

bind dual_link_sender dual_link_sender_chk #(
    .NUM_CH (NUM_CH),
    .WORD_W (lnk_pkg::WORD_W)
) u_chk (
    .lnk_clk       (lnk_clk),
    .lnk_rst       (lnk_rst),
    .ch_valid      (ch_valid),
    .ch_data       (ch_data),
    .ch_ctrl       (ch_ctrl),
    .ch_paused     (ch_paused),
    .ch_pause_seen (ch_pause_seen)
);

// File: tb/dual_link_sender_bench.sv
`timescale 1ns/100ps
module dual_link_sender_bench;
    localparam int AW = 3;
    localparam int NC = 2;
    localparam int W  = 32;

    logic src_clk = 1'b0;
    logic lnk_clk = 1'b0;
    always #5   src_clk = ~src_clk;
    always #6.5 lnk_clk = ~lnk_clk;

    logic            src_rst = 1'b1, lnk_rst = 1'b1;
    logic            src_valid = 1'b0, src_ctrl = 1'b0;
    logic [W-1:0]    src_data = '0;
    logic            src_ready;
    logic [NC-1:0]   ch_pause_req = '0;
    logic [NC-1:0]   ch_valid, ch_ctrl, ch_paused, ch_pause_seen;
    logic [NC*W-1:0] ch_data;

    dual_link_sender #(.ADDR_W(AW), .NUM_CH(NC)) u_dual_link_sender (
        .src_clk, .src_rst, .src_valid, .src_data, .src_ctrl, .src_ready,
        .lnk_clk, .lnk_rst, .ch_pause_req, .ch_valid, .ch_data, .ch_ctrl,
        .ch_paused, .ch_pause_seen
    );

    int checks = 0, errors = 0, mchecks = 0, merrors = 0, wd = 0;
    logic [W:0] exp_mem [0:1023];
    int wr_n = 0, quota = 0;
    int rd_n [NC];
    logic feed_on = 1'b0, halt = 1'b0;

    function automatic logic [W:0] gen(int k);
        logic [W-1:0] d;
        d = (k * 32'h9E3779B1) ^ (k << 7);
        return {((k % 5) == 0), d};
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors + merrors + wd, checks + mchecks + wd);
    endtask

    // Source feeder: a real word when ready, a marked junk word otherwise (R8).
    initial begin
        forever begin
            @(negedge src_clk);
            if (feed_on && !src_rst && wr_n < quota) begin
                if (src_ready) begin
                    exp_mem[wr_n] = gen(wr_n);
                    {src_ctrl, src_data} = gen(wr_n);
                    src_valid = 1'b1;
                    wr_n++;
                end else begin
                    src_valid = 1'b1;
                    src_data  = 32'hDEADBEEF;
                    src_ctrl  = 1'b1;
                end
            end else begin
                src_valid = 1'b0;
            end
        end
    end

    // Output monitor.
    initial begin
        for (int i = 0; i < NC; i++) rd_n[i] = 0;
        forever begin
            @(negedge lnk_clk);
            if (!lnk_rst) begin
                mchecks++;
                if (!(ch_valid == '0 || ch_valid == '1)) begin
                    merrors++;
                    $display("FAIL R3: actual=%b expected=all equal", ch_valid);
                end
                if (halt) begin
                    mchecks++;
                    if (ch_valid != '0) begin
                        merrors++;
                        $display("FAIL R4: actual=%b expected=0", ch_valid);
                    end
                end
                for (int i = 0; i < NC; i++) begin
                    mchecks++;
                    if (ch_valid[i]) begin
                        if (rd_n[i] >= wr_n) begin
                            merrors++;
                            $display("FAIL R8: actual=extra word %h expected=none", ch_data[i*W +: W]);
                        end else if ({ch_ctrl[i], ch_data[i*W +: W]} != exp_mem[rd_n[i]]) begin
                            merrors++;
                            $display("FAIL R2: actual=%h expected=%h",
                                     {ch_ctrl[i], ch_data[i*W +: W]}, exp_mem[rd_n[i]]);
                        end
                        rd_n[i]++;
                    end else if (ch_data[i*W +: W] != '0 || ch_ctrl[i]) begin
                        merrors++;
                        $display("FAIL R6: actual=%h expected=0", {ch_ctrl[i], ch_data[i*W +: W]});
                    end
                end
            end
        end
    end

    task automatic drain(input string req);
        for (int n = 0; n < 3000; n++) begin
            @(negedge lnk_clk);
            if (wr_n == quota && rd_n[0] == wr_n && rd_n[1] == wr_n) break;
        end
        repeat (4) @(negedge lnk_clk);
        chk(rd_n[0] == quota, req, rd_n[0], quota);
        chk(rd_n[1] == quota, req, rd_n[1], quota);
    endtask

    task automatic do_reset();
        src_rst = 1'b1; lnk_rst = 1'b1;
        repeat (6) @(negedge lnk_clk);
        chk(ch_valid == '0 && ch_ctrl == '0 && ch_data == '0, "R1", ch_valid, 0);
        chk(ch_pause_seen == '0, "R1", ch_pause_seen, 0);
        src_rst = 1'b0; lnk_rst = 1'b0;
        @(negedge src_clk);
        chk(src_ready == 1'b1, "R1", src_ready, 1);
    endtask

    initial begin
        do_reset();

        // Free-running stream.
        quota = 48; feed_on = 1'b1;
        drain("R2");

        // Every nonzero pause pattern.
        for (int pat = 1; pat < 4; pat++) begin
            int held;
            @(negedge lnk_clk);
            ch_pause_req = NC'(pat);
            repeat (3) @(posedge lnk_clk);
            #1 halt = 1'b1;
            quota += 40;
            repeat (80) @(negedge src_clk);
            chk(src_ready == 1'b0, "R5", src_ready, 0);
            chk(ch_paused == NC'(pat), "R10", ch_paused, pat);
            chk((ch_pause_seen & NC'(pat)) == NC'(pat), "R7", ch_pause_seen, pat);
            held = rd_n[0];
            repeat (20) @(negedge lnk_clk);
            chk(rd_n[0] == held, "R4", rd_n[0], held);
            @(negedge lnk_clk);
            ch_pause_req = '0; halt = 1'b0;
            repeat (4) @(negedge lnk_clk);
            chk(ch_paused == '0, "R10", ch_paused, 0);
            drain("R9");
            chk((ch_pause_seen & NC'(pat)) == NC'(pat), "R7", ch_pause_seen, pat);
        end
        chk(ch_pause_seen == 2'b11, "R7", ch_pause_seen, 3);
        chk(wr_n == quota, "R8", wr_n, quota);

        // Reset clears sticky state.
        feed_on = 1'b0;
        do_reset();
        chk(ch_pause_seen == '0, "R7", ch_pause_seen, 0);

        // Toggling pause on channel 1 while streaming.
        quota += 100; feed_on = 1'b1;
        for (int t = 0; t < 40; t++) begin
            @(negedge lnk_clk);
            ch_pause_req[1] = ~ch_pause_req[1];
            repeat (4) @(negedge lnk_clk);
        end
        ch_pause_req = '0;
        drain("R2");
        chk(ch_pause_seen == 2'b10, "R7", ch_pause_seen, 2);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge src_clk);
        wd = 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule